// File: doc/BRIEF.md
# Translation Cache with Global Entry Retention

This block is a small fully associative cache of address translations. Each slot holds a virtual page number, the physical frame number it maps to, and four permission bits: user access, writable, no-execute and global. A lookup strobe presents a virtual page number. One cycle later the block reports hit or miss and, on a hit, the frame and the permission bits. The permission check can therefore proceed without walking the page tables.

Three maintenance actions change the contents. A fill from the table walker installs a translation. It replaces an existing entry for the same page, or it takes the lowest-numbered empty slot, or it takes the slot a round-robin victim pointer names. A write of the page-table base register, including the reload on a task switch, flushes the cache. While the global-page enable is high, that flush spares entries marked global. A single-page invalidate removes the one entry for a given page, whether or not it is global.

Top module: `xlat_cache`

## Requirements
- R1: After a synchronous reset every slot is empty, the victim pointer is at slot 0 and `lk_hit` is 0.
- R2: A lookup presented with `lk_req` gives `lk_hit` one cycle later. On a hit, `lk_pfn` and `lk_perm` show the stored frame and permissions. On a miss, or in a cycle after no request, `lk_hit`, `lk_pfn` and `lk_perm` are all zero. `lk_perm`/`fill_perm` bit 0 is user, bit 1 writable, bit 2 no-execute, bit 3 global.
- R3: A fill of a page that is not present goes to the lowest-numbered empty slot. If no slot is empty, it goes to the slot the victim pointer names, and the pointer then advances by one modulo the slot count.
- R4: A fill of a page that is already present overwrites that slot. No duplicate is created and the victim pointer does not move.
- R5: A base-register write with `glb_en` = 0 empties every slot, including global ones.
- R6: A base-register write with `glb_en` = 1 keeps every slot whose global bit (bit 3) is 1 and empties all others.
- R7: A single-page invalidate empties only the slot that holds `inv_vpn`, even when that slot is global.
- R8: A lookup in the same cycle as a base-register write or an invalidate returns a miss.
- R9: When maintenance actions coincide, the base-register write wins over the invalidate, and the invalidate wins over the fill. The losing actions in that cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup strobe |
| lk_vpn | input | 20 | Virtual page number to look up |
| lk_hit | output | 1 | Registered hit result |
| lk_pfn | output | 24 | Frame number on a hit, else 0 |
| lk_perm | output | 4 | Permission bits on a hit, else 0 |
| fill_vld | input | 1 | Fill strobe from the table walker |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_pfn | input | 24 | Frame number to install |
| fill_perm | input | 4 | Permission bits to install |
| base_wr | input | 1 | Page-table base register written |
| glb_en | input | 1 | Global-page enable |
| inv_req | input | 1 | Single-page invalidate strobe |
| inv_vpn | input | 20 | Virtual page number to invalidate |

## Verification
The hardest case to reach from the ports is victim selection once the cache is full. The pointer moves only on fills that find neither a matching page nor an empty slot. Invalidates and retained global entries also leave holes that must be refilled before the pointer matters again. The bench drives long runs of fills with more distinct pages than there are slots, and mixes in global flushes and invalidates. A behavioural model predicts every eviction, and a lookup to each page then shows which entry was lost.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
    localparam int VPN_W = 20;
    localparam int PFN_W = 24;

    typedef struct packed {
        logic global;
        logic noexec;
        logic writable;
        logic user;
    } perm_t;

    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
        perm_t            perm;
    } slot_t;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_FILL  = 2'd1,
        OP_INVAL = 2'd2,
        OP_FLUSH = 2'd3
    } maint_e;

    function automatic logic slot_match(slot_t s, logic [VPN_W-1:0] key);
        return s.valid && (s.vpn == key);
    endfunction

    function automatic maint_e pick_op(logic base_wr, logic inv_req, logic fill_vld);
        if (base_wr)       return OP_FLUSH;
        else if (inv_req)  return OP_INVAL;
        else if (fill_vld) return OP_FILL;
        else               return OP_NONE;
    endfunction
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlbx_pkg::*;
#(
    parameter int N = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  slot_t            slots [N],
    input  logic [VPN_W-1:0] key,
    output logic [N-1:0]     hits
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hits[i] = slot_match(slots[i], key);
    end

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hits)); // R4
endmodule

// File: rtl/tlb_alloc.sv
module tlb_alloc
    import tlbx_pkg::*;
#(
    parameter int N = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     valid_vec,
    input  logic [N-1:0]     match_vec,
    input  logic             fill_go,
    output logic [IDX_W-1:0] fill_idx
);
    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] match_idx;
    logic [IDX_W-1:0] free_idx;
    logic             any_match;
    logic             any_free;

    always_comb begin
        match_idx = '0;
        any_match = 1'b0;
        free_idx  = '0;
        any_free  = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                match_idx = IDX_W'(i);
                any_match = 1'b1;
            end
            if (!valid_vec[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
        if (any_match)     fill_idx = match_idx;
        else if (any_free) fill_idx = free_idx;
        else               fill_idx = ptr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (fill_go && !any_match && !any_free) begin
            ptr_q <= (ptr_q == IDX_W'(N - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
        32'(ptr_q) < N); // R3
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (fill_go && any_match) |=> $stable(ptr_q)); // R4
endmodule

// File: rtl/tlb_array.sv
module tlb_array
    import tlbx_pkg::*;
#(
    parameter int N = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  maint_e           op,
    input  logic             glb_en,
    input  logic [N-1:0]     inv_hits,
    input  logic [IDX_W-1:0] fill_idx,
    input  slot_t            fill_slot,
    output slot_t            slots [N],
    output logic [N-1:0]     valid_vec
);
    logic [N-1:0] global_vec;

    for (genvar i = 0; i < N; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[i] <= '0;
            end else begin
                unique case (op)
                    OP_FLUSH: begin
                        if (!(glb_en && slots[i].perm.global))
                            slots[i].valid <= 1'b0;
                    end
                    OP_INVAL: begin
                        if (inv_hits[i])
                            slots[i].valid <= 1'b0;
                    end
                    OP_FILL: begin
                        if (fill_idx == IDX_W'(i))
                            slots[i] <= fill_slot;
                    end
                    default: ;
                endcase
            end
        end
        assign valid_vec[i]  = slots[i].valid;
        assign global_vec[i] = slots[i].perm.global;
    end

    AST_FLUSH_ALL: assert property (@(posedge clk) disable iff (rst)
        (op == OP_FLUSH && !glb_en) |=> (valid_vec == '0)); // R5
    AST_FLUSH_KEEP_GLOBAL: assert property (@(posedge clk) disable iff (rst)
        (op == OP_FLUSH && glb_en) |=> ((valid_vec & ~global_vec) == '0)); // R6
    AST_INVAL_GONE: assert property (@(posedge clk) disable iff (rst)
        (op == OP_INVAL) |=> ((valid_vec & $past(inv_hits)) == '0)); // R7
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import tlbx_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_req,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PFN_W-1:0] lk_pfn,
    output logic [3:0]       lk_perm,
    input  logic             fill_vld,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic [3:0]       fill_perm,
    input  logic             base_wr,
    input  logic             glb_en,
    input  logic             inv_req,
    input  logic [VPN_W-1:0] inv_vpn
);
    maint_e             op;
    slot_t              slots [ENTRIES];
    logic [ENTRIES-1:0] valid_vec;
    logic [ENTRIES-1:0] lk_hits;
    logic [ENTRIES-1:0] fill_hits;
    logic [ENTRIES-1:0] inv_hits;
    logic [IDX_W-1:0]   fill_idx;
    slot_t              fill_slot;
    slot_t              lk_sel;
    logic               lk_any;

    assign op        = pick_op(base_wr, inv_req, fill_vld);
    assign fill_slot = '{valid: 1'b1, vpn: fill_vpn, pfn: fill_pfn, perm: perm_t'(fill_perm)};

    tlb_cam #(.N(ENTRIES)) u_cam_lk (
        .clk(clk), .rst(rst), .slots(slots), .key(lk_vpn), .hits(lk_hits));
    tlb_cam #(.N(ENTRIES)) u_cam_fill (
        .clk(clk), .rst(rst), .slots(slots), .key(fill_vpn), .hits(fill_hits));
    tlb_cam #(.N(ENTRIES)) u_cam_inv (
        .clk(clk), .rst(rst), .slots(slots), .key(inv_vpn), .hits(inv_hits));

    tlb_alloc #(.N(ENTRIES)) u_alloc (
        .clk(clk), .rst(rst), .valid_vec(valid_vec), .match_vec(fill_hits),
        .fill_go(op == OP_FILL), .fill_idx(fill_idx));

    tlb_array #(.N(ENTRIES)) u_array (
        .clk(clk), .rst(rst), .op(op), .glb_en(glb_en), .inv_hits(inv_hits),
        .fill_idx(fill_idx), .fill_slot(fill_slot), .slots(slots), .valid_vec(valid_vec));

    always_comb begin
        lk_sel = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_hits[i]) lk_sel = lk_sel | slots[i];
        end
        lk_any = lk_req && (lk_hits != '0) && !base_wr && !inv_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lk_hit  <= 1'b0;
            lk_pfn  <= '0;
            lk_perm <= '0;
        end else begin
            lk_hit  <= lk_any;
            lk_pfn  <= lk_any ? lk_sel.pfn : '0;
            lk_perm <= lk_any ? 4'(lk_sel.perm) : 4'h0;
        end
    end

    AST_MAINT_MISS: assert property (@(posedge clk) disable iff (rst)
        (lk_req && (base_wr || inv_req)) |=> !lk_hit); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !lk_req |=> (!lk_hit && lk_pfn == '0 && lk_perm == '0)); // R2
endmodule

// File: tb/xlat_cache_test.sv
`timescale 1ns/1ps
module xlat_cache_test;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_req = 0, fill_vld = 0, base_wr = 0, glb_en = 0, inv_req = 0;
    logic [19:0] lk_vpn = 0, fill_vpn = 0, inv_vpn = 0;
    logic [23:0] fill_pfn = 0;
    logic [3:0]  fill_perm = 0;
    logic        lk_hit;
    logic [23:0] lk_pfn;
    logic [3:0]  lk_perm;

    always #2 clk = ~clk;

    xlat_cache #(.ENTRIES(N)) uut (
        .clk(clk), .rst(rst), .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_hit(lk_hit),
        .lk_pfn(lk_pfn), .lk_perm(lk_perm), .fill_vld(fill_vld), .fill_vpn(fill_vpn),
        .fill_pfn(fill_pfn), .fill_perm(fill_perm), .base_wr(base_wr), .glb_en(glb_en),
        .inv_req(inv_req), .inv_vpn(inv_vpn));

    // behavioural reference model
    bit          m_v [N];
    int          m_vpn [N];
    int          m_pfn [N];
    int          m_perm [N];
    int          m_ptr;
    bit          e_hit;
    int          e_pfn, e_perm;
    int          n_run = 0, n_fail = 0;
    bit          armed = 0;
    bit          done = 0;
    string       tag = "R1";

    always @(posedge clk) begin
        int slot;
        bit found;
        slot = -1;
        found = 0;
        e_hit = 0; e_pfn = 0; e_perm = 0;
        if (rst) begin
            foreach (m_v[i]) m_v[i] = 0;
            m_ptr = 0;
        end else begin
            if (lk_req && !base_wr && !inv_req)
                foreach (m_v[i])
                    if (m_v[i] && m_vpn[i] == int'(lk_vpn)) begin
                        e_hit = 1; e_pfn = m_pfn[i]; e_perm = m_perm[i];
                    end
            if (base_wr) begin
                foreach (m_v[i])
                    if (!(glb_en && m_perm[i][3])) m_v[i] = 0;
            end else if (inv_req) begin
                foreach (m_v[i])
                    if (m_v[i] && m_vpn[i] == int'(inv_vpn)) m_v[i] = 0;
            end else if (fill_vld) begin
                foreach (m_v[i])
                    if (m_v[i] && m_vpn[i] == int'(fill_vpn)) begin slot = i; found = 1; end
                if (!found)
                    for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
                if (slot < 0) begin
                    slot = m_ptr;
                    m_ptr = (m_ptr + 1) % N;
                end
                m_v[slot] = 1; m_vpn[slot] = int'(fill_vpn);
                m_pfn[slot] = int'(fill_pfn); m_perm[slot] = int'(fill_perm);
            end
        end
        armed = 1;
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (armed && !done) begin
            n_run++;
            if (lk_hit !== e_hit || int'(lk_pfn) != e_pfn || int'(lk_perm) != e_perm) begin
                n_fail++;
                $display("FAIL %s: hit/pfn/perm actual %0b/%0h/%0h expected %0b/%0h/%0h",
                         tag, lk_hit, lk_pfn, lk_perm, e_hit, e_pfn, e_perm);
            end
        end
    end

    task automatic clr();
        lk_req = 0; fill_vld = 0; base_wr = 0; inv_req = 0;
    endtask
    task automatic step();
        @(negedge clk); clr();
    endtask
    task automatic look(input int v);
        lk_req = 1; lk_vpn = 20'(v); step();
    endtask
    task automatic fill(input int v, input int p, input int a);
        fill_vld = 1; fill_vpn = 20'(v); fill_pfn = 24'(p); fill_perm = 4'(a); step();
    endtask
    task automatic flush(input bit ge);
        base_wr = 1; glb_en = ge; step();
    endtask
    task automatic inval(input int v);
        inv_req = 1; inv_vpn = 20'(v); step();
    endtask
    task automatic look_range(input int lo, input int hi);
        for (int v = lo; v <= hi; v++) look(v);
    endtask

    initial begin
        int lfsr;
        lfsr = 32'h1ACE5;
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst = 0;
        tag = "R1"; look(5); look(0); step();

        tag = "R2";
        fill(10, 'h111, 4'b0011); fill(11, 'h222, 4'b0101); fill(12, 'h333, 4'b1000);
        look(10); look(11); look(12); look(13); step();

        tag = "R4";
        fill(11, 'hABC, 4'b0110); look(11); inval(11); look(11);

        tag = "R3";
        for (int v = 20; v < 20 + N + 5; v++) fill(v, 'h1000 + v, v & 15);
        look_range(10, 20 + N + 5);
        inval(22); fill(40, 'h4040, 1); look_range(20, 41);

        tag = "R5";
        fill(50, 'h5050, 4'b1001); flush(0); look(50); look_range(20, 41);

        tag = "R6";
        fill(60, 'h60, 4'b1000); fill(61, 'h61, 4'b0001); fill(62, 'h62, 4'b1111);
        flush(1); look(60); look(61); look(62);

        tag = "R7";
        inval(62); look(62); look(60);

        tag = "R8";
        lk_req = 1; lk_vpn = 60; inv_req = 1; inv_vpn = 99; step(); step();
        lk_req = 1; lk_vpn = 60; base_wr = 1; glb_en = 1; step(); look(60);

        tag = "R9";
        fill_vld = 1; fill_vpn = 70; fill_pfn = 'h70; fill_perm = 0;
        inv_req = 1; inv_vpn = 60; step(); look(70); look(60);
        fill(71, 'h71, 0);
        fill_vld = 1; fill_vpn = 72; fill_pfn = 'h72; fill_perm = 0;
        inv_req = 1; inv_vpn = 71; base_wr = 1; glb_en = 0; step();
        look(71); look(72);

        tag = "R2";
        for (int k = 0; k < 3000; k++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB4BCD35C : 0);
            lk_req = lfsr[0]; lk_vpn = 20'(lfsr[7:4] % 12);
            case (lfsr[11:8])
                4'd0:  begin base_wr = 1; glb_en = lfsr[12]; end
                4'd1, 4'd2: begin inv_req = 1; inv_vpn = 20'(lfsr[16:13] % 12); end
                default: if (lfsr[17]) begin
                    fill_vld = 1; fill_vpn = 20'(lfsr[21:18] % 12);
                    fill_pfn = 24'(lfsr[30:20]); fill_perm = lfsr[25:22];
                end
            endcase
            step();
        end
        step();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule